// File: doc/BRIEF.md
# Truncating and Rounding Requantizer

This block shortens a signed two's complement sample by throwing away a run-time chosen number of low-order bits. The effect is to divide the sample by a power of two. One shared datapath serves two quantization laws, picked per sample. Truncation rounds toward minus infinity. Round-to-nearest sends an exact half step upward. Each accepted sample gives its result one clock later, and a new sample can be accepted every cycle.

Beside the quotient, the block returns the bits it discarded, right-aligned, so that a downstream checker or error accumulator can rebuild the exact input or measure the quantization error of each mode. In rounding mode the result can be a quotient one step above the largest code that the reduced word can hold. In that case the result is clipped to that code and a saturation flag is raised for that sample.

Top module: `requantizer`

## Requirements
- R1: A sample presented with `inValid` high at a rising edge gives its result, with `outValid` high, after that edge. `outValid` is otherwise low.
- R2: Truncation mode (`roundMode`=0) gives floor(x / 2^T), which is an arithmetic right shift by T. Examples: 31 with T=4 gives 1, 63 with T=4 gives 3, -1 with T=4 gives -1, and -17 with T=4 gives -2.
- R3: Rounding mode (`roundMode`=1) gives floor((x + 2^(T-1)) / 2^T), so a half step goes up. Examples with T=4: -8 gives 0, 8 gives 1, -9 gives -1, 24 gives 2, and 23 gives 1.
- R4: `outResidue` holds the T discarded input bits in its bits T-1..0, and zeros above them, in both modes.
- R5: With T=0 the input passes through unchanged in both modes, with zero residue and `outSat` low.
- R6: The largest code at shift T is (2^(IN_W-1)-1) >> T. In rounding mode, when the rounded quotient would exceed that code, `outWord` equals that code and `outSat` is 1. In every other case `outSat` is 0, and truncation never raises it.
- R7: A `shiftAmt` value above MAX_SHIFT (8) acts as a shift of MAX_SHIFT.
- R8: While `inValid` is low, `outWord`, `outResidue` and `outSat` keep their values and `outValid` is low.
- R9: Reset (`rstN` low, asynchronous) clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample qualifier |
| inWord | input | IN_W (16) | Signed input sample |
| roundMode | input | 1 | 0 truncate, 1 round to nearest (half up) |
| shiftAmt | input | $clog2(MAX_SHIFT+1) (4) | Number of low bits to discard, T |
| outValid | output | 1 | Result qualifier |
| outWord | output | IN_W (16) | Signed requantized quotient |
| outResidue | output | MAX_SHIFT (8) | Discarded bits, right-aligned, zero-extended |
| outSat | output | 1 | Rounding result clipped to the largest code |

## Verification
The hardest condition to reach is saturation. It needs rounding mode, a quotient already equal to the largest code for the chosen shift, and the top discarded bit set. Only a sliver of inputs near positive full scale meets all three, so random samples almost never hit it. The stimulus table places inputs at that edge for shifts 1 and 8, and also just beside it. The pseudo-random sweep biases part of its samples to within a few codes of positive full scale, so the clip is reached at many shift values.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic {
    RQ_TRUNC = 1'b0,
    RQ_ROUND = 1'b1
  } rq_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // capture a new result this cycle
    logic roundEn;    // apply the half-step increment
    logic zeroShift;  // effective shift is zero: bypass
  } rq_strobe_t;

endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            roundMode,
  input  logic [SH_W-1:0] shiftAmt,
  output rq_strobe_t      strobe,
  output logic [SH_W-1:0] amtEff,
  output logic            outValid
);

  localparam logic [SH_W-1:0] SHIFT_CAP = SH_W'(MAX_SHIFT);

  rq_mode_e modeSel;

  always_comb begin
    modeSel = rq_mode_e'(roundMode);
    amtEff  = (shiftAmt > SHIFT_CAP) ? SHIFT_CAP : shiftAmt;
    strobe.loadEn    = inValid;
    strobe.zeroShift = (amtEff == '0);
    strobe.roundEn   = inValid && (modeSel == RQ_ROUND) && (amtEff != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8

  AST_SHIFT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (shiftAmt > SHIFT_CAP) |-> (amtEff == SHIFT_CAP)); // R7

endmodule

// File: rtl/rq_datapath.sv
module rq_datapath
  import rq_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rq_strobe_t           strobe,
  input  logic [SH_W-1:0]      amt,
  input  logic [IN_W-1:0]      inWord,
  output logic [IN_W-1:0]      outWord,
  output logic [MAX_SHIFT-1:0] outResidue,
  output logic                 outSat
);

  localparam logic [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};

  logic signed [IN_W-1:0] shifted;
  logic [IN_W-1:0]        maxCode;
  logic [MAX_SHIFT-1:0]   residueBits;
  logic [MAX_SHIFT-1:0]   halfSel;
  logic                   halfBit;
  logic                   roundUp;
  logic                   satNext;
  logic [IN_W-1:0]        wordNext;

  // per-bit residue masking and selection of the top dropped bit
  for (genvar i = 0; i < MAX_SHIFT; i++) begin : g_drop
    assign residueBits[i] = (SH_W'(i) < amt) & inWord[i];
    assign halfSel[i]     = (amt == SH_W'(i + 1)) & inWord[i];
  end

  always_comb begin
    shifted  = $signed(inWord) >>> amt;
    maxCode  = POS_MAX >> amt;
    halfBit  = |halfSel;
    roundUp  = strobe.roundEn & halfBit;
    satNext  = roundUp && (shifted == $signed(maxCode));
    if (strobe.zeroShift)
      wordNext = inWord;
    else if (satNext)
      wordNext = maxCode;
    else
      wordNext = shifted + {{(IN_W-1){1'b0}}, roundUp};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord    <= '0;
      outResidue <= '0;
      outSat     <= 1'b0;
    end else if (strobe.loadEn) begin
      outWord    <= wordNext;
      outResidue <= residueBits;
      outSat     <= satNext;
    end
  end

  AST_TRUNC_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.roundEn) |=>
      (((outWord << $past(amt)) | IN_W'(outResidue)) == $past(inWord))); // R2

  AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && amt == '0) |=>
      (outWord == $past(inWord) && outResidue == '0 && !outSat)); // R5

  AST_SAT_ROUND_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.roundEn) |=> !outSat); // R6

  AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.roundEn) |=>
      (!outSat || outWord == (POS_MAX >> $past(amt)))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=>
      ($stable(outWord) && $stable(outResidue) && $stable(outSat))); // R8

endmodule

// File: rtl/requantizer.sv
module requantizer #(
  parameter int IN_W      = 16,
  parameter int MAX_SHIFT = 8,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [IN_W-1:0]      inWord,
  input  logic                 roundMode,
  input  logic [SH_W-1:0]      shiftAmt,
  output logic                 outValid,
  output logic [IN_W-1:0]      outWord,
  output logic [MAX_SHIFT-1:0] outResidue,
  output logic                 outSat
);

  rq_pkg::rq_strobe_t strobe;
  logic [SH_W-1:0]    amtEff;

  rq_ctrl #(
    .MAX_SHIFT(MAX_SHIFT),
    .SH_W     (SH_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .roundMode(roundMode),
    .shiftAmt (shiftAmt),
    .strobe   (strobe),
    .amtEff   (amtEff),
    .outValid (outValid)
  );

  rq_datapath #(
    .IN_W     (IN_W),
    .MAX_SHIFT(MAX_SHIFT),
    .SH_W     (SH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .amt       (amtEff),
    .inWord    (inWord),
    .outWord   (outWord),
    .outResidue(outResidue),
    .outSat    (outSat)
  );

endmodule

// File: tb/tb_requantizer.sv
module tb_requantizer;

  localparam int IN_W = 16;
  localparam int MS   = 8;
  localparam int SW   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [IN_W-1:0] inWord = '0;
  logic          roundMode = 1'b0;
  logic [SW-1:0] shiftAmt = '0;
  logic          outValid;
  logic [IN_W-1:0] outWord;
  logic [MS-1:0] outResidue;
  logic          outSat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  requantizer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .roundMode(roundMode), .shiftAmt(shiftAmt), .outValid(outValid),
    .outWord(outWord), .outResidue(outResidue), .outSat(outSat)
  );

  typedef struct packed {
    logic          md;
    logic [3:0]    sh;
    logic [15:0]   x;
    logic [15:0]   ew;
    logic [7:0]    er;
    logic          es;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd4, 16'd31,    16'd1,    8'h0F, 1'b0, 4'd2}, // R2 31/16 -> 1
    '{1'b0, 4'd4, 16'd63,    16'd3,    8'h0F, 1'b0, 4'd2}, // R2 63/16 -> 3
    '{1'b0, 4'd4, 16'hFFFF,  16'hFFFF, 8'h0F, 1'b0, 4'd2}, // R2 -1 -> -1
    '{1'b0, 4'd4, 16'hFFEF,  16'hFFFE, 8'h0F, 1'b0, 4'd2}, // R2 -17 -> -2
    '{1'b1, 4'd4, 16'hFFF8,  16'h0000, 8'h08, 1'b0, 4'd3}, // R3 -0.5 -> 0
    '{1'b1, 4'd4, 16'd8,     16'd1,    8'h08, 1'b0, 4'd3}, // R3 0.5 -> 1
    '{1'b1, 4'd4, 16'hFFF7,  16'hFFFF, 8'h07, 1'b0, 4'd3}, // R3 -9 -> -1
    '{1'b1, 4'd4, 16'd24,    16'd2,    8'h08, 1'b0, 4'd3}, // R3 1.5 -> 2
    '{1'b1, 4'd4, 16'd23,    16'd1,    8'h07, 1'b0, 4'd3}, // R3 23 -> 1
    '{1'b0, 4'd0, 16'h8000,  16'h8000, 8'h00, 1'b0, 4'd5}, // R5 trunc passthrough
    '{1'b1, 4'd0, 16'h7FFF,  16'h7FFF, 8'h00, 1'b0, 4'd5}, // R5 round passthrough
    '{1'b1, 4'd1, 16'h7FFF,  16'h3FFF, 8'h01, 1'b1, 4'd6}, // R6 clip at T=1
    '{1'b1, 4'd8, 16'h7F80,  16'h007F, 8'h80, 1'b1, 4'd6}, // R6 clip at T=8
    '{1'b1, 4'd8, 16'h7F7F,  16'h007F, 8'h7F, 1'b0, 4'd6}, // R6 just below clip
    '{1'b0, 4'd1, 16'h7FFF,  16'h3FFF, 8'h01, 1'b0, 4'd6}, // R6 trunc never clips
    '{1'b1, 4'd15, 16'h1234, 16'h0012, 8'h34, 1'b0, 4'd7}, // R7 15 acts as 8
    '{1'b0, 4'd9, 16'hFF00,  16'hFFFF, 8'h00, 1'b0, 4'd7}, // R7 9 acts as 8
    '{1'b1, 4'd8, 16'h8000,  16'hFF80, 8'h00, 1'b0, 4'd4}, // R4 most negative
    '{1'b1, 4'd3, 16'hFFFC,  16'h0000, 8'h04, 1'b0, 4'd4}  // R4 residue of -4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result derived from R3/R6/R7 formulas
  function automatic logic [24:0] model(logic rm, logic [3:0] sh, logic [15:0] x);
    int t;
    int xi;
    int q;
    int mx;
    logic s;
    logic [7:0] res;
    t  = (sh > 4'd8) ? 8 : int'(sh);
    xi = int'($signed(x));
    mx = 32767 >>> t;
    s  = 1'b0;
    if (rm && t > 0) q = (xi + (1 << (t - 1))) >>> t;
    else             q = xi >>> t;
    if (q > mx) begin
      q = mx;
      s = 1'b1;
    end
    res = 8'(xi & ((1 << t) - 1));
    return {s, res, 16'(q)};
  endfunction

  task automatic drive(input logic rm, input logic [3:0] sh, input logic [15:0] x);
    @(negedge clk);
    inValid   = 1'b1;
    roundMode = rm;
    shiftAmt  = sh;
    inWord    = x;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [24:0] exp;
    logic [15:0] xs;
    lfsr = 32'h1ACE_B00C;

    // R9: outputs during reset
    #22;
    chk("R9 reset", {6'd0, outValid, outSat, outResidue, outWord}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: nothing appears before the edge, result after it
    @(negedge clk);
    inValid = 1'b1; roundMode = 1'b0; shiftAmt = 4'd2; inWord = 16'd13;
    #1;
    chk("R1 before edge", {15'd0, outValid, outWord}, 32'd0);
    @(posedge clk);
    #2;
    chk("R1 after edge", {15'd0, outValid, outWord}, {15'd0, 1'b1, 16'd3});

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].md, VECS[i].sh, VECS[i].x);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i),
          {6'd0, outValid, outSat, outResidue, outWord},
          {6'd0, 1'b1, VECS[i].es, VECS[i].er, VECS[i].ew});
    end

    // R8: idle cycles keep the last result (last vector) despite new inputs
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      inValid   = 1'b0;
      roundMode = ~roundMode;
      shiftAmt  = 4'(k + 1);
      inWord    = 16'h7FFF - 16'(k);
      @(posedge clk);
      #2;
      chk("R8 hold", {6'd0, outValid, outSat, outResidue, outWord},
          {6'd0, 1'b0, 1'b0, 8'h04, 16'h0000});
    end

    // saturation after idle: R6 at T=5
    drive(1'b1, 4'd5, 16'h7FF0);
    chk("R6 clip T=5", {6'd0, outValid, outSat, outResidue, outWord},
        {6'd0, 1'b1, 1'b1, 8'h10, 16'h03FF});

    // pseudo-random sweep, biased toward positive full scale
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      xs = lfsr[31:16];
      if (lfsr[3:1] == 3'd0) xs = 16'h7FFF - {13'd0, lfsr[10:8]} * 16'd16;
      drive(lfsr[0], lfsr[7:4], xs);
      exp = model(lfsr[0], lfsr[7:4], xs);
      chk(lfsr[0] ? "R3 R6 sweep" : "R2 R4 sweep",
          {6'd0, outValid, outSat, outResidue, outWord}, {6'd0, 1'b1, exp});
    end

    // R9: asynchronous reset mid-run
    @(negedge clk);
    inValid = 1'b0;
    #2;
    rstN = 1'b0;
    #1;
    chk("R9 async reset", {6'd0, outValid, outSat, outResidue, outWord}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule